// File: doc/BRIEF.md
# I2C Slave Address Comparator

This block decides whether the first byte of a serial bus transfer addresses this device. A bit-level receiver upstream hands it each completed 8-bit byte with a one-cycle valid strobe, together with one-cycle pulses that mark START and STOP conditions on the bus. Only the first byte after a START is evaluated. It is compared against a programmed own-address register in one of three ways. In 7-bit mode the upper seven bits are compared and the low bit is taken as the direction. In 10-bit mode the whole register is compared. In free-data mode no comparison is made and every transfer is accepted.

The all-zero general-call byte is also recognised as a valid addressing event in the two addressing modes. It raises a separate flag alongside the match output. The result is registered and holds for the rest of the transfer. The next START or a STOP clears it. Bit shifting and acknowledge generation happen elsewhere; the acknowledge logic consumes `addr_hit` and `gen_call`.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset `addr_hit`, `gen_call` and `rd_wrn` are all 0.
- R2: In 7-bit mode (`free_fmt`=0, `addr10_sel`=0) the first byte after a START sets `addr_hit` to 1 on the clock edge after its `byte_vld` when `rx_byte[7:1]` equals `own_addr[7:1]`; `rx_byte[0]` plays no part in the comparison.
- R3: In 7-bit mode a first byte whose bits 7..1 differ from `own_addr[7:1]` and that is not 0x00 leaves `addr_hit` at 0.
- R4: In 10-bit mode (`free_fmt`=0, `addr10_sel`=1) `addr_hit` is set only when all eight bits of the first byte equal `own_addr`.
- R5: In free-data mode (`free_fmt`=1, either `addr10_sel`) any first byte sets `addr_hit` to 1, and `gen_call` stays 0 even for 0x00.
- R6: In either addressing mode a first byte of 0x00 sets both `gen_call` and `addr_hit` to 1.
- R7: `rd_wrn` takes bit 0 of the evaluated first byte (1 = read) on the same edge as `addr_hit`.
- R8: Bytes after the first one in a transfer do not change `addr_hit`, `gen_call` or `rd_wrn`.
- R9: A `start_det` or `stop_det` pulse clears `addr_hit`, `gen_call` and `rd_wrn` on the next clock edge. If `byte_vld` arrives in the same cycle, the pulse takes priority and the byte is dropped.
- R10: Bytes that arrive while no START has been seen since reset or since the last STOP are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | One-cycle pulse: START or repeated START seen on the bus |
| stop_det | input | 1 | One-cycle pulse: STOP seen on the bus |
| byte_vld | input | 1 | One-cycle strobe: `rx_byte` holds a completed byte |
| rx_byte | input | 8 | Received byte, MSB first on the wire |
| own_addr | input | 8 | Programmed own-address register |
| free_fmt | input | 1 | 1 = free-data format, no address check |
| addr10_sel | input | 1 | 1 = compare all register bits, 0 = upper seven only |
| addr_hit | output | 1 | Device addressed (or free format) in this transfer |
| gen_call | output | 1 | First byte was the general call |
| rd_wrn | output | 1 | Direction bit of the first byte, 1 = read |

## Verification
If the first-byte tracker holds the wrong state, a later data byte is compared as if it were an address. A wrong bit then appears on `addr_hit`, `gen_call` or `rd_wrn` one edge after the second `byte_vld`. A wrong compare mask or mode decode shows on `addr_hit` one edge after the first byte, so the bench uses addresses that differ only in bit 0 and only in bit 7. A missing clear leaves a stale `addr_hit` visible one edge after START or STOP, before any byte arrives.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;

   typedef enum logic [1:0] {
      AM_7BIT  = 2'd0,
      AM_10BIT = 2'd1,
      AM_FREE  = 2'd2
   } addr_mode_e;

   typedef struct packed {
      logic hit;
      logic gc;
   } cmp_res_t;

   function automatic addr_mode_e decode_mode(input logic free_fmt, input logic addr10);
      if (free_fmt)    return AM_FREE;
      else if (addr10) return AM_10BIT;
      else             return AM_7BIT;
   endfunction

endpackage

// File: rtl/i2cam_cmp.sv
module i2cam_cmp
   import i2cam_pkg::*;
#(
   parameter int                BYTE_W  = 8,
   parameter bit                GC_EN   = 1'b1,
   parameter logic [BYTE_W-1:0] GC_CODE = '0
) (
   input  addr_mode_e        mode,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic [BYTE_W-1:0] own_addr,
   output cmp_res_t          res
);

   localparam int HI = BYTE_W - 1;

   if (BYTE_W < 2) begin : g_bad_width
      $error("i2cam_cmp: BYTE_W must be at least 2");
   end

   logic eq_upper;
   logic eq_full;
   logic gc_seen;

   assign eq_upper = (rx_byte[HI:1] == own_addr[HI:1]);
   assign eq_full  = (rx_byte == own_addr);

   if (GC_EN) begin : g_gc_on
      assign gc_seen = (rx_byte == GC_CODE) && (mode != AM_FREE);
   end else begin : g_gc_off
      assign gc_seen = 1'b0;
   end

   always_comb begin
      res.gc = gc_seen;
      unique case (mode)
         AM_7BIT:  res.hit = eq_upper | gc_seen;
         AM_10BIT: res.hit = eq_full  | gc_seen;
         AM_FREE:  res.hit = 1'b1;
         default:  res.hit = 1'b0;
      endcase
   end

   always_comb begin
      a_r6_gc_implies_hit: assert (!res.gc || res.hit);
   end

endmodule

// File: rtl/i2cam_seq.sv
module i2cam_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic start_det,
   input  logic stop_det,
   input  logic byte_vld,
   output logic first_pend,
   output logic eval,
   output logic clr
);

   assign clr  = start_det | stop_det;
   assign eval = byte_vld & first_pend & ~clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         first_pend <= 1'b0;
      else if (start_det) first_pend <= 1'b1;
      else if (stop_det)  first_pend <= 1'b0;
      else if (byte_vld)  first_pend <= 1'b0;
   end

   a_r10_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> first_pend);
   a_r8_one_eval: assert property (@(posedge clk) disable iff (!rst_n)
      eval |=> !first_pend);
   a_r10_stop_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> !first_pend);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
   import i2cam_pkg::*;
#(
   parameter int                BYTE_W  = 8,
   parameter bit                GC_EN   = 1'b1,
   parameter logic [BYTE_W-1:0] GC_CODE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic [BYTE_W-1:0] own_addr,
   input  logic              free_fmt,
   input  logic              addr10_sel,
   output logic              addr_hit,
   output logic              gen_call,
   output logic              rd_wrn
);

   addr_mode_e mode;
   cmp_res_t   res;
   logic       first_pend;
   logic       eval;
   logic       clr;

   assign mode = decode_mode(free_fmt, addr10_sel);

   i2cam_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .byte_vld   (byte_vld),
      .first_pend (first_pend),
      .eval       (eval),
      .clr        (clr)
   );

   i2cam_cmp #(
      .BYTE_W  (BYTE_W),
      .GC_EN   (GC_EN),
      .GC_CODE (GC_CODE)
   ) u_cmp (
      .mode     (mode),
      .rx_byte  (rx_byte),
      .own_addr (own_addr),
      .res      (res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_hit <= 1'b0;
         gen_call <= 1'b0;
         rd_wrn   <= 1'b0;
      end else if (clr) begin
         addr_hit <= 1'b0;
         gen_call <= 1'b0;
         rd_wrn   <= 1'b0;
      end else if (eval) begin
         addr_hit <= res.hit;
         gen_call <= res.gc;
         rd_wrn   <= rx_byte[0];
      end
   end

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!addr_hit && !gen_call && !rd_wrn));
   a_r7_direction: assert property (@(posedge clk) disable iff (!rst_n)
      eval |=> (rd_wrn == $past(rx_byte[0])));
   a_r5_free_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && free_fmt) |=> (addr_hit && !gen_call));
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!first_pend && !clr) |=> ($stable(addr_hit) && $stable(gen_call) && $stable(rd_wrn)));
   a_r6_gc_flag: assert property (@(posedge clk) disable iff (!rst_n)
      gen_call |-> addr_hit);

endmodule

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_det = 1'b0;
   logic       stop_det = 1'b0;
   logic       byte_vld = 1'b0;
   logic [7:0] rx_byte = '0;
   logic [7:0] own_addr = 8'hA4;
   logic       free_fmt = 1'b0;
   logic       addr10_sel = 1'b0;
   logic       addr_hit;
   logic       gen_call;
   logic       rd_wrn;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   i2c_addr_match i_i2c_addr_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .byte_vld   (byte_vld),
      .rx_byte    (rx_byte),
      .own_addr   (own_addr),
      .free_fmt   (free_fmt),
      .addr10_sel (addr10_sel),
      .addr_hit   (addr_hit),
      .gen_call   (gen_call),
      .rd_wrn     (rd_wrn)
   );

   task automatic check3(input string req, input logic eh, input logic eg, input logic er);
      checks++;
      if (addr_hit !== eh || gen_call !== eg || rd_wrn !== er) begin
         errors++;
         $display("FAIL %s: hit/gc/rw = %b%b%b expected %b%b%b",
                  req, addr_hit, gen_call, rd_wrn, eh, eg, er);
      end
   endtask

   // inputs change on the falling edge; results are registered on the rising edge
   task automatic pulse_start();
      @(negedge clk); start_det = 1'b1;
      @(negedge clk); start_det = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk); stop_det = 1'b1;
      @(negedge clk); stop_det = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk); rx_byte = b; byte_vld = 1'b1;
      @(negedge clk); byte_vld = 1'b0;
   endtask

   task automatic t_reset();
      check3("R1 reset", 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_seven_bit();
      free_fmt = 1'b0; addr10_sel = 1'b0; own_addr = 8'hA4;
      pulse_start(); send_byte(8'hA5);
      check3("R2 7-bit match read", 1'b1, 1'b0, 1'b1);
      pulse_start(); send_byte(8'hA4);
      check3("R7 7-bit match write", 1'b1, 1'b0, 1'b0);
      pulse_start(); send_byte(8'hA6);
      check3("R3 7-bit mismatch bit1", 1'b0, 1'b0, 1'b0);
      pulse_start(); send_byte(8'h25);
      check3("R3 7-bit mismatch bit7", 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_ten_bit();
      free_fmt = 1'b0; addr10_sel = 1'b1; own_addr = 8'hF2;
      pulse_start(); send_byte(8'hF2);
      check3("R4 10-bit full match", 1'b1, 1'b0, 1'b0);
      pulse_start(); send_byte(8'hF3);
      check3("R4 10-bit bit0 differs", 1'b0, 1'b0, 1'b1);
      pulse_start(); send_byte(8'h00);
      check3("R6 gc in 10-bit mode", 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_gen_call();
      free_fmt = 1'b0; addr10_sel = 1'b0; own_addr = 8'hA4;
      pulse_start(); send_byte(8'h00);
      check3("R6 gc in 7-bit mode", 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_free();
      free_fmt = 1'b1; addr10_sel = 1'b0; own_addr = 8'hA4;
      pulse_start(); send_byte(8'h37);
      check3("R5 free any byte", 1'b1, 1'b0, 1'b1);
      addr10_sel = 1'b1;
      pulse_start(); send_byte(8'h00);
      check3("R5 free 0x00 no gc", 1'b1, 1'b0, 1'b0);
      free_fmt = 1'b0; addr10_sel = 1'b0;
   endtask

   task automatic t_hold_and_clear();
      own_addr = 8'hA4;
      pulse_start(); send_byte(8'hA5);
      send_byte(8'h00);
      check3("R8 later gc byte ignored", 1'b1, 1'b0, 1'b1);
      send_byte(8'h12);
      check3("R8 later byte ignored", 1'b1, 1'b0, 1'b1);
      @(negedge clk); stop_det = 1'b1;
      @(negedge clk); stop_det = 1'b0;
      check3("R9 stop clears", 1'b0, 1'b0, 1'b0);
      send_byte(8'hA5);
      check3("R10 byte after stop ignored", 1'b0, 1'b0, 1'b0);
      pulse_start(); send_byte(8'h00);
      @(negedge clk); start_det = 1'b1;
      @(negedge clk); start_det = 1'b0;
      check3("R9 repeated start clears", 1'b0, 1'b0, 1'b0);
      // byte coinciding with START is dropped; the next byte is the first one
      @(negedge clk); start_det = 1'b1; rx_byte = 8'hA5; byte_vld = 1'b1;
      @(negedge clk); start_det = 1'b0; byte_vld = 1'b0;
      check3("R9 byte with start dropped", 1'b0, 1'b0, 1'b0);
      send_byte(8'hA4);
      check3("R9 first byte after collision", 1'b1, 1'b0, 1'b0);
      pulse_stop();
   endtask

   task automatic t_idle();
      send_byte(8'hA5);
      check3("R10 byte before any start", 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle();
      t_seven_bit();
      t_ten_bit();
      t_gen_call();
      t_free();
      t_hold_and_clear();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: done = 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule